// File: doc/BRIEF.md
# SDRAM Write-Burst Command Sequencer

This block sits on the controller side of an SDRAM interface. It carries out one complete write transaction to an already-initialised device. A request names a bank, a row, a column and four data words. The block opens the row with ACTIVE and then issues WRITE, driving the four words on four consecutive cycles starting with the WRITE cycle. After the write recovery interval it closes the row with an explicit PRECHARGE. Every cycle that carries none of these three commands carries NOP.

Each minimum interval between commands is a cycle-count parameter, rounded up from the device figure in nanoseconds at the design clock. The intervals are row-to-column delay, row active time, row cycle time, write recovery and precharge time, and each one is enforced by a countdown timer of its own. Every command is issued on the earliest cycle that meets all the intervals that apply to it. The block accepts a new request only once the following ACTIVE can legally fall on the next cycle.

A request flag chooses whether the PRECHARGE closes only the addressed bank or every bank. Data leaves on a separate output bus with an output enable, which a pad ring turns into the bidirectional DQ pins. The reset input is expected to be already synchronised to the clock on release.

Top module: `sdram_wr_seq`

## Requirements
- R1: While rst_n is low, sd_cke is 0, the command is NOP, sd_dq_oe is 0, sd_dqm is 1 and req_ready is 0. In the first cycle after the first clock edge following release, req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. In the cycle after that edge the command is ACTIVE, sd_addr carries the row zero-extended, and sd_ba carries the bank.
- R3: WRITE comes exactly T_RCD cycles after ACTIVE. sd_addr carries the column on its low COL_W bits, and every other bit is 0, including bit 10, which disables auto-precharge. sd_ba carries the bank.
- R4: Data words 0 to 3 of req_data (word i at bits [i*DATA_W +: DATA_W]) appear on sd_dq_out in the WRITE cycle and the three cycles after it, in that order. sd_dq_oe is 1 and sd_dqm is 0 in exactly those four cycles; outside them sd_dq_oe is 0 and sd_dqm is 1.
- R5: PRECHARGE comes exactly max(T_RCD+3+T_WR, T_RAS) cycles after ACTIVE. This is the earliest cycle that is at least T_WR after the last data word and at least T_RAS after ACTIVE.
- R6: During PRECHARGE, sd_addr[10] equals the captured req_all_banks flag (1 = all banks, 0 = only the bank on sd_ba), and sd_ba carries the bank.
- R7: req_ready next becomes 1 in the cycle that makes the following ACTIVE land exactly max(P+T_RP, T_RC) cycles after the previous ACTIVE, where P is the PRECHARGE offset.
- R8: Commands are encoded on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} as follows: NOP = 0111, ACTIVE = 0011, WRITE = 0100, PRECHARGE = 0010. Every cycle other than the three command cycles carries NOP.
- R9: While req_ready is 0, req_valid and all request fields are ignored. No extra ACTIVE is issued, and the transaction in progress keeps the fields captured when it was accepted.
- R10: sd_cke is 1 from the first cycle after reset release onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted on this edge |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_all_banks | input | 1 | Precharge all banks instead of only the target |
| req_data | input | 4*DATA_W | Four burst words, word 0 in the low bits |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_ba | output | BANK_W | Bank address |
| sd_dqm | output | 1 | Data mask, low while writing |
| sd_dq_out | output | DATA_W | Write data towards the pads |
| sd_dq_oe | output | 1 | Data output enable |

## Verification
Two instances run side by side. In one, write recovery and precharge time bind; in the other, row active time and row cycle time bind. A design that enforced only one of the pair would issue PRECHARGE or the next ACTIVE a cycle or more early on one instance. Back-to-back requests with no idle gap check that the ready cycle is exactly right: a ready that came one cycle late would shift the next ACTIVE, and one that came early would violate the row cycle time. The stimulus also holds req_valid high with changing fields during the busy window. A sequencer that listened then would emit a stray ACTIVE, and one that read the fields live would write the wrong column, bank or data. Full-scale row, column and bank values expose any column bit or bit 10 that leaks into the WRITE address.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTW,
    ST_BURST,
    ST_REC
  } seq_state_e;

  localparam int TI_RCD = 0;
  localparam int TI_RAS = 1;
  localparam int TI_RC  = 2;
  localparam int TI_WR  = 3;
  localparam int TI_RP  = 4;
  localparam int N_TMR  = 5;

  localparam int BURST_LEN = 4;
  localparam int AP_BIT    = 10;

endpackage

// File: rtl/sdram_wr_timer.sv
module sdram_wr_timer #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int CW = $clog2(LEN + 1) < 1 ? 1 : $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  // A command placed on edge e meets the interval on edge e' when e'-e >= LEN,
  // i.e. when at most one decrement is still outstanding.
  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = CW'(LEN);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q <= CW'(1));

endmodule

// File: rtl/sdram_wr_ctrl.sv
module sdram_wr_ctrl
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [COL_W-1:0]            req_col,
  input  logic                        req_all_banks,
  input  logic [BURST_LEN*DATA_W-1:0] req_data,
  input  logic [N_TMR-1:0]            tmr_done,
  output logic [N_TMR-1:0]            tmr_load,
  output logic                        cke,
  output sd_cmd_e                     cmd,
  output logic [ADDR_W-1:0]           addr,
  output logic [BANK_W-1:0]           ba,
  output logic                        dqm,
  output logic [DATA_W-1:0]           dq_out,
  output logic                        dq_oe
);

  localparam int BW = $clog2(BURST_LEN);

  seq_state_e state_q, state_d;
  logic [BW-1:0] beat_q, beat_d;

  logic [BANK_W-1:0]                  bank_q;
  logic [COL_W-1:0]                   col_q;
  logic                               all_q;
  logic [BURST_LEN-1:0][DATA_W-1:0]   data_q;
  logic                               cap_en;

  sd_cmd_e           cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BANK_W-1:0] ba_d;
  logic              dqm_d, oe_d;
  logic [DATA_W-1:0] dq_d;

  assign req_ready = (state_q == ST_IDLE) && cke && tmr_done[TI_RP] && tmr_done[TI_RC];
  assign cap_en    = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    ba_d     = bank_q;
    dq_d     = '0;
    oe_d     = 1'b0;
    dqm_d    = 1'b1;
    tmr_load = '0;
    case (state_q)
      ST_IDLE: begin
        if (cap_en) begin
          cmd_d            = CMD_ACT;
          addr_d           = ADDR_W'(req_row);
          ba_d             = req_bank;
          tmr_load[TI_RCD] = 1'b1;
          tmr_load[TI_RAS] = 1'b1;
          tmr_load[TI_RC]  = 1'b1;
          state_d          = ST_ACTW;
        end
      end
      ST_ACTW: begin
        if (tmr_done[TI_RCD]) begin
          cmd_d          = CMD_WR;
          addr_d         = ADDR_W'(col_q);
          addr_d[AP_BIT] = 1'b0;
          dq_d           = data_q[0];
          oe_d           = 1'b1;
          dqm_d          = 1'b0;
          beat_d         = BW'(1);
          state_d        = ST_BURST;
        end
      end
      ST_BURST: begin
        dq_d   = data_q[beat_q];
        oe_d   = 1'b1;
        dqm_d  = 1'b0;
        beat_d = beat_q + 1'b1;
        if (beat_q == BW'(BURST_LEN - 1)) begin
          tmr_load[TI_WR] = 1'b1;
          state_d         = ST_REC;
        end
      end
      ST_REC: begin
        if (tmr_done[TI_WR] && tmr_done[TI_RAS]) begin
          cmd_d           = CMD_PRE;
          addr_d[AP_BIT]  = all_q;
          tmr_load[TI_RP] = 1'b1;
          state_d         = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      cke     <= 1'b0;
      cmd     <= CMD_NOP;
      addr    <= '0;
      ba      <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      dqm     <= 1'b1;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      cke     <= 1'b1;
      cmd     <= cmd_d;
      addr    <= addr_d;
      ba      <= ba_d;
      dq_out  <= dq_d;
      dq_oe   <= oe_d;
      dqm     <= dqm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      all_q  <= 1'b0;
      data_q <= '0;
    end else if (cap_en) begin
      bank_q <= req_bank;
      col_q  <= req_col;
      all_q  <= req_all_banks;
      data_q <= req_data;
    end
  end

  assert_wr_no_autopre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) |-> (addr[AP_BIT] == 1'b0));

  assert_dqm_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dqm);

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (cmd != CMD_ACT));

  assert_cke_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cke);

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 7,
  parameter int T_RC   = 10,
  parameter int T_WR   = 3,
  parameter int T_RP   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [COL_W-1:0]        req_col,
  input  logic                    req_all_banks,
  input  logic [4*DATA_W-1:0]     req_data,
  output logic                    sd_cke,
  output logic                    sd_cs_n,
  output logic                    sd_ras_n,
  output logic                    sd_cas_n,
  output logic                    sd_we_n,
  output logic [ADDR_W-1:0]       sd_addr,
  output logic [BANK_W-1:0]       sd_ba,
  output logic                    sd_dqm,
  output logic [DATA_W-1:0]       sd_dq_out,
  output logic                    sd_dq_oe
);

  function automatic int tmr_len(input int idx);
    case (idx)
      TI_RCD:  return T_RCD;
      TI_RAS:  return T_RAS;
      TI_RC:   return T_RC;
      TI_WR:   return T_WR;
      default: return T_RP;
    endcase
  endfunction

  logic [N_TMR-1:0] tmr_done, tmr_load;
  sd_cmd_e          cmd;

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    sdram_wr_timer #(.LEN(tmr_len(gi))) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load[gi]),
      .done (tmr_done[gi])
    );
  end

  sdram_wr_ctrl #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_bank     (req_bank),
    .req_row      (req_row),
    .req_col      (req_col),
    .req_all_banks(req_all_banks),
    .req_data     (req_data),
    .tmr_done     (tmr_done),
    .tmr_load     (tmr_load),
    .cke          (sd_cke),
    .cmd          (cmd),
    .addr         (sd_addr),
    .ba           (sd_ba),
    .dqm          (sd_dqm),
    .dq_out       (sd_dq_out),
    .dq_oe        (sd_dq_oe)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // Spacing watch on the pins: cycles since the last ACTIVE, PRECHARGE and data word.
  localparam int SMAX = T_RCD + T_RAS + T_RC + T_WR + T_RP + 8;
  localparam int SW   = $clog2(SMAX + 1);

  logic [SW-1:0] since_act, since_pre, since_dat;
  logic          seen_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= SW'(SMAX);
      since_pre <= SW'(SMAX);
      since_dat <= SW'(SMAX);
      seen_pre  <= 1'b0;
    end else begin
      since_act <= (cmd == CMD_ACT) ? SW'(1) : (since_act == SW'(SMAX) ? since_act : since_act + 1'b1);
      since_pre <= (cmd == CMD_PRE) ? SW'(1) : (since_pre == SW'(SMAX) ? since_pre : since_pre + 1'b1);
      since_dat <= sd_dq_oe         ? SW'(1) : (since_dat == SW'(SMAX) ? since_dat : since_dat + 1'b1);
      if (cmd == CMD_PRE) seen_pre <= 1'b1;
    end
  end

  assert_rcd_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) |-> (since_act >= SW'(T_RCD)));

  assert_pre_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (since_act >= SW'(T_RAS) && since_dat >= SW'(T_WR)));

  assert_next_act_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && seen_pre) |-> (since_pre >= SW'(T_RP) && since_act >= SW'(T_RC)));

endmodule

// File: tb/test_sdram_wr_seq.sv
module wr_seq_agent #(
  parameter int          ROW_W  = 12,
  parameter int          COL_W  = 8,
  parameter int          BANK_W = 2,
  parameter int          DATA_W = 16,
  parameter int          ADDR_W = 12,
  parameter int          T_RCD  = 3,
  parameter int          T_RAS  = 7,
  parameter int          T_RC   = 10,
  parameter int          T_WR   = 3,
  parameter int          T_RP   = 3,
  parameter int          NTXN   = 40,
  parameter int unsigned SEED   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [BANK_W-1:0]   req_bank,
  output logic [ROW_W-1:0]    req_row,
  output logic [COL_W-1:0]    req_col,
  output logic                req_all_banks,
  output logic [4*DATA_W-1:0] req_data,
  input  logic                sd_cke,
  input  logic                sd_cs_n,
  input  logic                sd_ras_n,
  input  logic                sd_cas_n,
  input  logic                sd_we_n,
  input  logic [ADDR_W-1:0]   sd_addr,
  input  logic [BANK_W-1:0]   sd_ba,
  input  logic                sd_dqm,
  input  logic [DATA_W-1:0]   sd_dq_out,
  input  logic                sd_dq_oe,
  output int                  n_chk,
  output int                  n_fail,
  output logic                done
);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_WR = 4'b0100, C_PRE = 4'b0010;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int W_OFS = T_RCD;
  localparam int P_OFS = max2(T_RCD + 3 + T_WR, T_RAS);
  localparam int N_OFS = max2(P_OFS + T_RP, T_RC);

  function automatic logic [3:0] exp_cmd(input int k);
    if (k == 0)     return C_ACT;
    if (k == W_OFS) return C_WR;
    if (k == P_OFS) return C_PRE;
    return C_NOP;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_wr_addr(input logic [COL_W-1:0] c);
    logic [ADDR_W-1:0] a;
    a = '0;
    for (int i = 0; i < COL_W; i++) if (i != 10) a[i] = c[i];
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s in %m at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic junk();
    req_valid     = 1'($urandom);
    req_bank      = BANK_W'($urandom);
    req_row       = ROW_W'($urandom);
    req_col       = COL_W'($urandom);
    req_all_banks = 1'($urandom);
    req_data      = {$urandom, $urandom};
  endtask

  task automatic do_txn(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                        input logic [COL_W-1:0] c, input logic all,
                        input logic [4*DATA_W-1:0] d, input int gap, input bit noisy);
    logic [3:0] ec;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(req_ready == 1'b1, "R7 ready stays up while idle", req_ready, 1);
      chk(cmd_now() == C_NOP, "R8 idle NOP", cmd_now(), C_NOP);
      req_valid = 1'b0;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready at earliest legal cycle", req_ready, 1);
    chk(cmd_now() == C_NOP, "R8 NOP before accept", cmd_now(), C_NOP);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_all_banks = all; req_data = d;
    for (int k = 0; k < N_OFS - 1; k++) begin
      @(negedge clk);
      ec = exp_cmd(k);
      chk(cmd_now() == ec, (k == W_OFS) ? "R3 WRITE cycle" : (k == P_OFS) ? "R5 PRECHARGE cycle" :
          (k == 0) ? "R2 ACTIVE cycle" : "R8 NOP / R9 no stray command", cmd_now(), ec);
      chk(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
      chk(sd_cke == 1'b1, "R10 cke high", sd_cke, 1);
      if (k == 0) begin
        chk(sd_addr == ADDR_W'(r), "R2 row on address", sd_addr, ADDR_W'(r));
        chk(sd_ba == b, "R2 bank on ACTIVE", sd_ba, b);
      end
      if (k == W_OFS) begin
        chk(sd_addr == exp_wr_addr(c), "R3 column address, bit10 low", sd_addr, exp_wr_addr(c));
        chk(sd_ba == b, "R3 R9 bank on WRITE", sd_ba, b);
      end
      if (k == P_OFS) begin
        chk(sd_addr[10] == all, "R6 precharge mode bit", sd_addr[10], all);
        chk(sd_ba == b, "R6 bank on PRECHARGE", sd_ba, b);
      end
      if (k >= W_OFS && k <= W_OFS + 3) begin
        chk(sd_dq_oe == 1'b1 && sd_dqm == 1'b0, "R4 drive and unmask in burst",
            {sd_dq_oe, sd_dqm}, 2'b10);
        chk(sd_dq_out == d[(k - W_OFS)*DATA_W +: DATA_W], "R4 R9 burst word order",
            sd_dq_out, d[(k - W_OFS)*DATA_W +: DATA_W]);
      end else begin
        chk(sd_dq_oe == 1'b0 && sd_dqm == 1'b1, "R4 released outside burst",
            {sd_dq_oe, sd_dqm}, 2'b01);
      end
      if (noisy) junk();
      else       req_valid = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(SEED));
    n_chk = 0; n_fail = 0; done = 1'b0;
    req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
    req_all_banks = 1'b0; req_data = '0;
    @(negedge clk);
    chk(rst_n == 1'b0, "R1 bench in reset", rst_n, 0);
    chk(sd_cke == 1'b0, "R1 cke low in reset", sd_cke, 0);
    chk(cmd_now() == C_NOP, "R1 NOP in reset", cmd_now(), C_NOP);
    chk(sd_dq_oe == 1'b0 && sd_dqm == 1'b1, "R1 bus released in reset", {sd_dq_oe, sd_dqm}, 2'b01);
    chk(req_ready == 1'b0, "R1 not ready in reset", req_ready, 0);
    wait (rst_n);
    @(negedge clk);
    chk(sd_cke == 1'b1, "R10 cke high after release", sd_cke, 1);
    chk(req_ready == 1'b1, "R1 ready after release", req_ready, 1);
    // directed corners: full-scale fields, back-to-back, zero fields, long gap
    do_txn('1, '1, '1, 1'b1, {4{DATA_W'('1)}}, 0, 1'b0);
    do_txn('0, '0, '0, 1'b0, {DATA_W'(4), DATA_W'(3), DATA_W'(2), DATA_W'(1)}, 0, 1'b1);
    do_txn(BANK_W'(1), ROW_W'(1 << 10), COL_W'(8'hA5), 1'b0, {$urandom, $urandom}, 3, 1'b1);
    for (int t = 0; t < NTXN; t++)
      do_txn(BANK_W'($urandom), ROW_W'($urandom), COL_W'($urandom), 1'($urandom),
             {$urandom, $urandom}, int'($urandom % 3), 1'($urandom));
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after last", req_ready, 1);
    req_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(cmd_now() == C_NOP, "R8 NOP when idle", cmd_now(), C_NOP);
    end
    done = 1'b1;
  end

endmodule

module test_sdram_wr_seq;

  localparam int DW = 16;

  logic clk, rst_n;

  // instance a: defaults (write recovery and precharge time bind)
  logic a_valid, a_ready, a_all, a_cke, a_cs, a_ras, a_cas, a_we, a_dqm, a_oe, a_done;
  logic [1:0] a_bank, a_ba;
  logic [11:0] a_row, a_addr;
  logic [7:0] a_col;
  logic [4*DW-1:0] a_data;
  logic [DW-1:0] a_dq;
  int a_chk, a_fail;

  // instance b: row active and row cycle time bind
  logic b_valid, b_ready, b_all, b_cke, b_cs, b_ras, b_cas, b_we, b_dqm, b_oe, b_done;
  logic [1:0] b_bank, b_ba;
  logic [11:0] b_row, b_addr;
  logic [7:0] b_col;
  logic [4*DW-1:0] b_data;
  logic [DW-1:0] b_dq;
  int b_chk, b_fail;

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  end

  sdram_wr_seq i_sdram_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready), .req_bank(a_bank),
    .req_row(a_row), .req_col(a_col), .req_all_banks(a_all), .req_data(a_data),
    .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_addr(a_addr), .sd_ba(a_ba), .sd_dqm(a_dqm), .sd_dq_out(a_dq), .sd_dq_oe(a_oe)
  );

  wr_seq_agent #(.NTXN(40), .SEED(32'h1234)) u_agent_a (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready), .req_bank(a_bank),
    .req_row(a_row), .req_col(a_col), .req_all_banks(a_all), .req_data(a_data),
    .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_addr(a_addr), .sd_ba(a_ba), .sd_dqm(a_dqm), .sd_dq_out(a_dq), .sd_dq_oe(a_oe),
    .n_chk(a_chk), .n_fail(a_fail), .done(a_done)
  );

  sdram_wr_seq #(.T_RCD(2), .T_RAS(8), .T_RC(13), .T_WR(2), .T_RP(2)) i_sdram_wr_seq_b (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready), .req_bank(b_bank),
    .req_row(b_row), .req_col(b_col), .req_all_banks(b_all), .req_data(b_data),
    .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_addr(b_addr), .sd_ba(b_ba), .sd_dqm(b_dqm), .sd_dq_out(b_dq), .sd_dq_oe(b_oe)
  );

  wr_seq_agent #(.T_RCD(2), .T_RAS(8), .T_RC(13), .T_WR(2), .T_RP(2), .NTXN(40),
                 .SEED(32'h5678)) u_agent_b (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready), .req_bank(b_bank),
    .req_row(b_row), .req_col(b_col), .req_all_banks(b_all), .req_data(b_data),
    .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_addr(b_addr), .sd_ba(b_ba), .sd_dqm(b_dqm), .sd_dq_out(b_dq), .sd_dq_oe(b_oe),
    .n_chk(b_chk), .n_fail(b_fail), .done(b_done)
  );

  initial begin
    int cyc;
    int wd_fail;
    cyc = 0;
    wd_fail = 0;
    while (!(a_done === 1'b1 && b_done === 1'b1) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(a_done === 1'b1 && b_done === 1'b1)) begin
      wd_fail = 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected completion", cyc);
    end
    $display("%0d/%0d checks passed",
             (a_chk + b_chk + wd_fail) - (a_fail + b_fail + wd_fail), a_chk + b_chk + wd_fail);
    $finish;
  end

endmodule